// File: doc/BRIEF.md
# IEEE-754 Double Rounding and Flag Unit

This block is the last stage of a double-precision arithmetic datapath. An upstream unit hands it a result that is not yet rounded: a sign, a biased exponent that may lie outside the encodable range, a 53-bit significand with its leading bit, three extra low-order bits (guard, round, sticky), and a two-bit kind code for results that need no rounding. The unit applies the selected rounding mode and packs the 64-bit word. It also raises the overflow, underflow, inexact, invalid and combined exception flags.

Values whose exponent falls below the normal range are shifted right into the denormal range before rounding, and every discarded bit is folded into sticky. A rounding carry out of the largest denormal produces the smallest normal. Overflow saturates to infinity or to the largest finite magnitude, depending on the mode and the sign. The unit has one registered stage and a valid pulse on each side.

Top module: `fpr_round_unit`

## Requirements
- R1: Rounding mode code 00 selects round-to-nearest. A discarded part above half rounds up. A discarded part of exactly half (guard 1, round 0, sticky 0) rounds to the even significand.
- R2: Mode code 01 truncates. The magnitude never increases.
- R3: Mode code 10 adds one ulp only to positive values, and code 11 only to negative values, whenever guard, round or sticky is set.
- R4: When rounding carries out of an all-ones significand, the exponent rises by one and the fraction becomes zero.
- R5: A finite input with a biased exponent below 1 is shifted right by (1 - exponent) places, with each shifted-out bit ORed into sticky. It is packed with an exponent field of 0 unless rounding restores the leading bit.
- R6: A tiny value whose rounding carries into the leading bit (largest denormal rounding up) is packed with an exponent field of 1 and a zero fraction.
- R7: A rounded exponent of 2047 or more is an overflow. The result is infinity in mode 00, and also in mode 10 for a positive sign or mode 11 for a negative sign. Otherwise the result is 0x7FEFFFFFFFFFFFFF with the sign applied. Overflow and inexact are both set.
- R8: Inexact is set when guard, round or sticky (after any denormal shift) is nonzero, or on overflow.
- R9: Underflow is set when the value is tiny before rounding (exponent 1 after alignment with leading bit 0) and inexact. An exact tiny value raises no flag.
- R10: Kind code 10 passes a NaN through, with its payload taken from significand bits 51..0 and the sign kept. Fraction bit 51 is forced to 1, and invalid is set when that bit was 0 on input (signalling NaN). Kind code 11 is an invalid operation: it returns 0x7FF8000000000000 and sets invalid.
- R11: Kind code 01 returns a signed infinity with no flag set. Kind code 00 is a finite value to be rounded.
- R12: The exception flag equals the OR of invalid, overflow and underflow.
- R13: Synchronous reset clears all outputs to zero. A result and its flags appear in the cycle after in_valid, together with a one-cycle out_valid. Outputs hold their values while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_rmode | input | 2 | Rounding mode code |
| in_kind | input | 2 | 00 finite, 01 infinity, 10 NaN pass-through, 11 invalid operation |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 13 | Biased exponent, two's complement |
| in_sig | input | 53 | Significand with leading bit at 52, or NaN payload in 51..0 |
| in_grs | input | 3 | Guard, round, sticky (bit 2 is guard) |
| out_valid | output | 1 | Result registered this cycle |
| out_fp | output | 64 | Packed double result |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |
| out_invalid | output | 1 | Invalid flag |
| out_exception | output | 1 | OR of invalid, overflow, underflow |

## Verification
A wrong increment decision or a lost sticky bit shows up as a fraction that is off by one ulp in the very next result. The same cycle also shows an inexact flag that disagrees with the discarded bits. A faulty denormal shift or exponent fix-up corrupts the exponent field by whole binades, and this appears most clearly at the boundary between denormals and normals and in the overflow saturation value. Because the unit has a single stage, every fault is visible one cycle after the input that triggers it, with no hidden state carried into later results.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int FRAC_W = 52;
  localparam int EXPF_W = 11;
  localparam int EXPI_W = 13;

  typedef enum logic [1:0] {
    KIND_FINITE = 2'b00,
    KIND_INF    = 2'b01,
    KIND_NAN    = 2'b10,
    KIND_INVOP  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;

  // decide whether to add one ulp to the kept significand
  function automatic logic round_up(input logic [1:0] rm, input logic sign,
                                    input logic lsb, input logic g,
                                    input logic r, input logic s);
    logic dropped;
    dropped = g | r | s;
    case (rmode_e'(rm))
      RM_NEAR: return g & (r | s | lsb);
      RM_ZERO: return 1'b0;
      RM_POS:  return ~sign & dropped;
      default: return sign & dropped;
    endcase
  endfunction

  // on overflow: 1 = clamp to largest finite, 0 = infinity
  function automatic logic clamp_finite(input logic [1:0] rm, input logic sign);
    case (rmode_e'(rm))
      RM_NEAR: return 1'b0;
      RM_ZERO: return 1'b1;
      RM_POS:  return sign;
      default: return ~sign;
    endcase
  endfunction

endpackage

// File: rtl/fpr_denorm_align.sv
module fpr_denorm_align #(
  parameter int FRAC_W = fpr_pkg::FRAC_W,
  parameter int EXPI_W = fpr_pkg::EXPI_W
) (
  input  logic [EXPI_W-1:0] exp_in,
  input  logic [FRAC_W:0]   sig_in,
  input  logic [2:0]        grs_in,
  output logic [EXPI_W-1:0] exp_out,
  output logic [FRAC_W:0]   sig_out,
  output logic [2:0]        grs_out,
  output logic              tiny
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + 3;
  localparam int SH_W  = EXPI_W + 1;

  logic [EXT_W-1:0] ext, shifted, drop_mask;
  logic [SH_W-1:0]  shamt;
  logic             below, saturate, lost;

  always_comb begin
    ext       = {sig_in, grs_in};
    below     = exp_in[EXPI_W-1] | (exp_in == '0);
    shamt     = SH_W'(1) - {exp_in[EXPI_W-1], exp_in};
    saturate  = (shamt >= SH_W'(EXT_W));
    drop_mask = saturate ? '1 : ((EXT_W'(1) << shamt) - EXT_W'(1));
    shifted   = saturate ? '0 : (ext >> shamt);
    lost      = |(ext & drop_mask);
    if (below) begin
      exp_out = EXPI_W'(1);
      sig_out = shifted[EXT_W-1:3];
      grs_out = {shifted[2:1], shifted[0] | lost};
    end else begin
      exp_out = exp_in;
      sig_out = sig_in;
      grs_out = grs_in;
    end
    tiny = (exp_out == EXPI_W'(1)) && !sig_out[FRAC_W];
  end

  // a nonzero value never vanishes: shifted-out bits survive as sticky
  always_comb begin
    AST_STICKY_KEPT: assert (!(below && (|ext)) || (|{sig_out, grs_out})) else $error("sticky lost"); // R5
  end

endmodule

// File: rtl/fpr_round_core.sv
module fpr_round_core #(
  parameter int FRAC_W = fpr_pkg::FRAC_W,
  parameter int EXPI_W = fpr_pkg::EXPI_W
) (
  input  logic [1:0]        rmode,
  input  logic              sign,
  input  logic [EXPI_W-1:0] exp_in,
  input  logic [FRAC_W:0]   sig_in,
  input  logic [2:0]        grs_in,
  output logic [EXPI_W:0]   exp_out,
  output logic [FRAC_W:0]   sig_out,
  output logic              inexact_raw,
  output logic              carry_out
);
  localparam int SIG_W = FRAC_W + 1;

  logic [SIG_W:0] sum;
  logic           inc;

  always_comb begin
    inc         = fpr_pkg::round_up(rmode, sign, sig_in[0], grs_in[2], grs_in[1], grs_in[0]);
    inexact_raw = |grs_in;
    sum         = {1'b0, sig_in} + (SIG_W+1)'(inc);
    carry_out   = sum[SIG_W];
    sig_out     = carry_out ? sum[SIG_W:1] : sum[SIG_W-1:0];
    exp_out     = {exp_in[EXPI_W-1], exp_in} + {{EXPI_W{1'b0}}, carry_out};
  end

  // a carry can only leave an all-ones significand
  always_comb begin
    AST_CARRY_FROM_ONES: assert (!carry_out || (&sig_in)) else $error("carry from non-ones"); // R4
  end

endmodule

// File: rtl/fpr_pack.sv
module fpr_pack #(
  parameter int FRAC_W = fpr_pkg::FRAC_W,
  parameter int EXPF_W = fpr_pkg::EXPF_W,
  parameter int EXPI_W = fpr_pkg::EXPI_W
) (
  input  logic [1:0]              kind,
  input  logic [1:0]              rmode,
  input  logic                    sign,
  input  logic [EXPI_W:0]         exp_r,
  input  logic [FRAC_W:0]         sig_r,
  input  logic                    tiny,
  input  logic                    inexact_raw,
  input  logic [FRAC_W-1:0]       payload,
  output logic [EXPF_W+FRAC_W:0]  result,
  output logic                    ovf,
  output logic                    unf,
  output logic                    inx,
  output logic                    inv,
  output logic                    exc
);
  localparam int EXP_MAX = (1 << EXPF_W) - 1;

  logic              ovf_event;
  logic              denorm_carry;
  logic [EXPF_W-1:0] exp_field;

  always_comb begin
    ovf_event    = (fpr_pkg::kind_e'(kind) == fpr_pkg::KIND_FINITE) &&
                   !exp_r[EXPI_W] && (exp_r[EXPI_W-1:0] >= EXPI_W'(EXP_MAX));
    denorm_carry = tiny && sig_r[FRAC_W];
    exp_field    = sig_r[FRAC_W] ? exp_r[EXPF_W-1:0] : '0;
    ovf = 1'b0; unf = 1'b0; inx = 1'b0; inv = 1'b0;
    case (fpr_pkg::kind_e'(kind))
      fpr_pkg::KIND_FINITE: begin
        if (ovf_event) begin
          ovf = 1'b1;
          inx = 1'b1;
          if (fpr_pkg::clamp_finite(rmode, sign))
            result = {sign, EXPF_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
          else
            result = {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
          inx    = inexact_raw;
          unf    = tiny & inexact_raw;
          result = {sign, exp_field, sig_r[FRAC_W-1:0]};
        end
      end
      fpr_pkg::KIND_INF: result = {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      fpr_pkg::KIND_NAN: begin
        inv    = ~payload[FRAC_W-1];
        result = {sign, {EXPF_W{1'b1}}, 1'b1, payload[FRAC_W-2:0]};
      end
      default: begin
        inv    = 1'b1;
        result = {1'b0, {EXPF_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      end
    endcase
    exc = inv | ovf | unf;
  end

  // carry out of the largest denormal lands on exponent 1, fraction 0
  always_comb begin
    AST_DENORM_CARRY: assert (!(denorm_carry && !ovf_event && kind == 2'b00) ||
                              (result[EXPF_W+FRAC_W-1:FRAC_W] == EXPF_W'(1) && result[FRAC_W-1:0] == '0))
      else $error("denormal carry mispacked"); // R6
  end

endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit #(
  parameter int FRAC_W = fpr_pkg::FRAC_W,
  parameter int EXPF_W = fpr_pkg::EXPF_W,
  parameter int EXPI_W = fpr_pkg::EXPI_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [1:0]             in_rmode,
  input  logic [1:0]             in_kind,
  input  logic                   in_sign,
  input  logic [EXPI_W-1:0]      in_exp,
  input  logic [FRAC_W:0]        in_sig,
  input  logic [2:0]             in_grs,
  output logic                   out_valid,
  output logic [EXPF_W+FRAC_W:0] out_fp,
  output logic                   out_overflow,
  output logic                   out_underflow,
  output logic                   out_inexact,
  output logic                   out_invalid,
  output logic                   out_exception
);
  localparam int WORD_W = EXPF_W + FRAC_W + 1;

  logic [EXPI_W-1:0] al_exp;
  logic [FRAC_W:0]   al_sig;
  logic [2:0]        al_grs;
  logic              al_tiny;
  logic [EXPI_W:0]   rn_exp;
  logic [FRAC_W:0]   rn_sig;
  logic              rn_inexact, rn_carry;
  logic [WORD_W-1:0] pk_word;
  logic              pk_ovf, pk_unf, pk_inx, pk_inv, pk_exc;

  fpr_denorm_align #(.FRAC_W(FRAC_W), .EXPI_W(EXPI_W)) u_align (
    .exp_in(in_exp), .sig_in(in_sig), .grs_in(in_grs),
    .exp_out(al_exp), .sig_out(al_sig), .grs_out(al_grs), .tiny(al_tiny)
  );

  fpr_round_core #(.FRAC_W(FRAC_W), .EXPI_W(EXPI_W)) u_round (
    .rmode(in_rmode), .sign(in_sign), .exp_in(al_exp), .sig_in(al_sig), .grs_in(al_grs),
    .exp_out(rn_exp), .sig_out(rn_sig), .inexact_raw(rn_inexact), .carry_out(rn_carry)
  );

  fpr_pack #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .EXPI_W(EXPI_W)) u_pack (
    .kind(in_kind), .rmode(in_rmode), .sign(in_sign), .exp_r(rn_exp), .sig_r(rn_sig),
    .tiny(al_tiny), .inexact_raw(rn_inexact), .payload(in_sig[FRAC_W-1:0]),
    .result(pk_word), .ovf(pk_ovf), .unf(pk_unf), .inx(pk_inx), .inv(pk_inv), .exc(pk_exc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_fp        <= '0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
      out_invalid   <= 1'b0;
      out_exception <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fp        <= pk_word;
        out_overflow  <= pk_ovf;
        out_underflow <= pk_unf;
        out_inexact   <= pk_inx;
        out_invalid   <= pk_inv;
        out_exception <= pk_exc;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R13
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_fp) && !out_valid)); // R13
  AST_UNDERFLOW_INEXACT: assert property (@(posedge clk) disable iff (rst) out_underflow |-> out_inexact); // R9
  AST_OVERFLOW_INEXACT: assert property (@(posedge clk) disable iff (rst) out_overflow |-> out_inexact); // R8
  AST_OVERFLOW_WORD: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> (out_fp[WORD_W-2:FRAC_W+1] == '1)); // R7
  AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> ((&out_fp[WORD_W-2:FRAC_W]) && out_fp[FRAC_W-1])); // R10
  AST_EXC_COVERS: assert property (@(posedge clk) disable iff (rst)
    (out_overflow || out_underflow || out_invalid) |-> out_exception); // R12

endmodule

// File: tb/fpr_round_unit_bench.sv
module fpr_round_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic [1:0]  in_kind = 2'b00;
  logic        in_sign = 1'b0;
  logic [12:0] in_exp = '0;
  logic [52:0] in_sig = '0;
  logic [2:0]  in_grs = '0;
  logic        out_valid;
  logic [63:0] out_fp;
  logic        out_overflow, out_underflow, out_inexact, out_invalid, out_exception;

  int tests = 0;
  int fails = 0;
  logic [68:0] last_exp;

  always #10 clk = ~clk;

  fpr_round_unit u_fpr_round_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_rmode(in_rmode), .in_kind(in_kind),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_grs(in_grs),
    .out_valid(out_valid), .out_fp(out_fp), .out_overflow(out_overflow),
    .out_underflow(out_underflow), .out_inexact(out_inexact), .out_invalid(out_invalid),
    .out_exception(out_exception)
  );

  function automatic logic [68:0] mk(input logic [63:0] fp, input logic o, input logic u,
                                     input logic x, input logic i);
    return {fp, o, u, x, i, o | u | i};
  endfunction

  // bench model: bit-serial denormal shift, explicit mode table
  function automatic logic [68:0] ref_out(input logic [1:0] m, input logic [1:0] k, input logic sg,
                                          input int e, input logic [52:0] sig, input logic [2:0] grs);
    logic [55:0] v;
    logic [53:0] sum;
    logic [63:0] fp;
    logic tiny, any, up, ovf, unf, inx, inv;
    int ee;
    ovf = 0; unf = 0; inx = 0; inv = 0; fp = '0;
    if (k == 2'b01) fp = {sg, 11'h7FF, 52'h0};
    else if (k == 2'b10) begin fp = {sg, 11'h7FF, 1'b1, sig[50:0]}; inv = !sig[51]; end
    else if (k == 2'b11) begin fp = 64'h7FF8000000000000; inv = 1; end
    else begin
      v = {sig, grs}; ee = e;
      if (ee < 1) begin
        for (int i = 0; i < 1 - ee && i < 60; i++) v = (v >> 1) | {55'd0, v[0]};
        ee = 1;
      end
      tiny = (ee == 1) && !v[55];
      any = |v[2:0];
      case (m)
        2'b00: up = v[2] & (v[1] | v[0] | v[3]);
        2'b01: up = 0;
        2'b10: up = !sg & any;
        default: up = sg & any;
      endcase
      sum = {1'b0, v[55:3]} + 54'(up);
      if (sum[53]) begin sum = sum >> 1; ee++; end
      if (ee >= 2047) begin
        ovf = 1; inx = 1;
        if (m == 2'b00 || (m == 2'b10 && !sg) || (m == 2'b11 && sg)) fp = {sg, 11'h7FF, 52'h0};
        else fp = {sg, 11'h7FE, {52{1'b1}}};
      end else begin
        inx = any; unf = tiny & any;
        fp = {sg, sum[52] ? 11'(ee) : 11'h0, sum[51:0]};
      end
    end
    return {fp, ovf, unf, inx, inv, ovf | unf | inv};
  endfunction

  task automatic check(input logic [68:0] expv, input string tag);
    logic [68:0] act;
    act = {out_fp, out_overflow, out_underflow, out_inexact, out_invalid, out_exception};
    tests++;
    if (act !== expv || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: got %h v=%b expected %h v=1", tag, act, out_valid, expv);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [1:0] k, input logic sg, input int e,
                     input logic [52:0] sig, input logic [2:0] grs, input logic [68:0] expv,
                     input string tag);
    @(negedge clk);
    in_rmode = m; in_kind = k; in_sign = sg; in_exp = e[12:0]; in_sig = sig; in_grs = grs;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(expv, tag);
    last_exp = expv;
  endtask

  localparam logic [52:0] ONE  = 53'h10000000000000;
  localparam logic [52:0] ONES = {53{1'b1}};

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tests++;
    if ({out_valid, out_fp, out_overflow, out_underflow, out_inexact, out_invalid, out_exception} !== '0) begin
      fails++;
      $display("FAIL R13 reset: got %h expected 0", out_fp);
    end
    // R1 ties to even
    run(2'b00, 2'b00, 0, 1023, ONE, 3'b100, mk(64'h3FF0000000000000, 0, 0, 1, 0), "R1 tie even");
    run(2'b00, 2'b00, 0, 1023, ONE | 53'd1, 3'b100, mk(64'h3FF0000000000002, 0, 0, 1, 0), "R1 tie odd");
    run(2'b00, 2'b00, 0, 1023, ONE, 3'b101, mk(64'h3FF0000000000001, 0, 0, 1, 0), "R1 above half");
    // R2 truncate
    run(2'b01, 2'b00, 0, 1023, ONE | 53'd1, 3'b111, mk(64'h3FF0000000000001, 0, 0, 1, 0), "R2 truncate");
    // R3 directed
    run(2'b10, 2'b00, 0, 1023, ONE, 3'b001, mk(64'h3FF0000000000001, 0, 0, 1, 0), "R3 up positive");
    run(2'b10, 2'b00, 1, 1023, ONE, 3'b001, mk(64'hBFF0000000000000, 0, 0, 1, 0), "R3 up negative");
    run(2'b11, 2'b00, 1, 1023, ONE, 3'b001, mk(64'hBFF0000000000001, 0, 0, 1, 0), "R3 down negative");
    run(2'b11, 2'b00, 0, 1023, ONE, 3'b001, mk(64'h3FF0000000000000, 0, 0, 1, 0), "R3 down positive");
    // R4 significand carry
    run(2'b10, 2'b00, 0, 1023, ONES, 3'b001, mk(64'h4000000000000000, 0, 0, 1, 0), "R4 carry");
    // R5 gradual underflow
    run(2'b00, 2'b00, 0, 0, ONE, 3'b000, mk(64'h0008000000000000, 0, 0, 0, 0), "R5 R9 exact denormal");
    run(2'b10, 2'b00, 0, -100, ONE, 3'b000, mk(64'h0000000000000001, 0, 1, 1, 0), "R5 deep sticky up");
    run(2'b00, 2'b00, 0, -100, ONE, 3'b000, mk(64'h0000000000000000, 0, 1, 1, 0), "R9 flush nearest");
    // R6 largest denormal to smallest normal
    run(2'b00, 2'b00, 0, 1, {1'b0, {52{1'b1}}}, 3'b100, mk(64'h0010000000000000, 0, 1, 1, 0), "R6 denorm carry");
    // R7 overflow per mode
    run(2'b00, 2'b00, 0, 2047, ONE, 3'b000, mk(64'h7FF0000000000000, 1, 0, 1, 0), "R7 nearest inf");
    run(2'b01, 2'b00, 0, 2047, ONE, 3'b000, mk(64'h7FEFFFFFFFFFFFFF, 1, 0, 1, 0), "R7 zero clamp");
    run(2'b10, 2'b00, 1, 2047, ONE, 3'b000, mk(64'hFFEFFFFFFFFFFFFF, 1, 0, 1, 0), "R7 up neg clamp");
    run(2'b11, 2'b00, 1, 2047, ONE, 3'b000, mk(64'hFFF0000000000000, 1, 0, 1, 0), "R7 down neg inf");
    run(2'b10, 2'b00, 0, 2046, ONES, 3'b001, mk(64'h7FF0000000000000, 1, 0, 1, 0), "R7 R8 round into ovf");
    run(2'b00, 2'b00, 0, 1023, ONE, 3'b000, mk(64'h3FF0000000000000, 0, 0, 0, 0), "R8 exact");
    // R10 NaN, R11 infinity
    run(2'b00, 2'b10, 0, 0, 53'd5, 3'b000, mk(64'h7FF8000000000005, 0, 0, 0, 1), "R10 R12 signalling");
    run(2'b00, 2'b10, 1, 0, 53'h8000000000007, 3'b000, mk(64'hFFF8000000000007, 0, 0, 0, 0), "R10 quiet");
    run(2'b01, 2'b11, 1, 5, ONE, 3'b111, mk(64'h7FF8000000000000, 0, 0, 0, 1), "R10 invalid op");
    run(2'b00, 2'b01, 1, 5, ONE, 3'b111, mk(64'hFFF0000000000000, 0, 0, 0, 0), "R11 infinity");
    // R13 hold while idle
    @(negedge clk);
    in_sig = ONES; in_exp = 13'd3000; in_grs = 3'b111; in_kind = 2'b00;
    @(negedge clk);
    tests++;
    if ({out_fp, out_overflow, out_underflow, out_inexact, out_invalid, out_exception} !== last_exp || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R13 hold: got %h v=%b expected %h v=0", out_fp, out_valid, last_exp[68:5]);
    end
    // random mix (R1-related checks via model)
    for (int n = 0; n < 4000; n++) begin
      int e;
      logic [52:0] s;
      logic [1:0] k;
      case ($urandom % 4)
        0: e = -60 + int'($urandom % 62);
        1: e = 2 + int'($urandom % 2039);
        2: e = 2040 + int'($urandom % 21);
        default: e = -3 + int'($urandom % 7);
      endcase
      s = {$urandom, $urandom} & ONES;
      if ($urandom % 4 == 0) s = ONES ^ 53'($urandom % 4);
      if (e >= 2) s[52] = 1'b1;
      k = ($urandom % 16 == 0) ? 2'($urandom) : 2'b00;
      begin
        logic [1:0] m;
        logic sg;
        logic [2:0] g;
        m = 2'($urandom); sg = 1'($urandom); g = 3'($urandom);
        run(m, k, sg, e, s, g, ref_out(m, k, sg, e, s, g), "R1 R2 R3 R5 R7 R9 random");
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule